// File: doc/BRIEF.md
# Link Port Control and Interrupt Register File

This block is the software-visible register set of one storage-link port, reached over a plain 32-bit memory-mapped bus with single-cycle write and read strobes. It keeps a control word that software changes through a set address and a separate clear address. Reading the set address returns a status view: the stored control bits plus a port-ready flag. A port-reset control bit takes the port out of the ready state. After the bit is released, a parameterised number of cycles pass before ready comes back.

Twelve event inputs, each a one-cycle pulse from the surrounding port logic, are caught in sticky status bits. A single status read shows every pending event unmasked in its upper half. The lower half shows the same events gated by an enable mask. The enable mask and a 2-bit steering field are also changed through set and clear addresses. One control bit picks how software acknowledges events: either by writing ones to the status register, or by reading it, which clears whatever that read reported. The interrupt output is the OR of the masked events and is forced low while the port is in reset.

Top module: `lnk_port_regs`

## Requirements
- R1: After reset the control bits, status, enables and steering are zero, port-ready is 1, the interrupt is low and read data is zero.
- R2: A write to offset 0x1000 sets each control bit 30:0 written as one. A read of 0x1000 returns port-ready in bit 31 and the control bits in bits 30:0.
- R3: A write to offset 0x1004 clears each control bit 30:0 written as one and leaves the others unchanged. Bit 31 of such a write has no effect.
- R4: Port reset is control bit 0. Port-ready reads 0 from the write that sets it. Once a write clears it at edge E, port-ready becomes 1 at edge E+READY_DELAY and not before.
- R5: An event pulse on ev_i[i] sets sticky status bit i. A read of 0x1008 returns all pending bits in bits 27:16, and in bits 11:0 only the pending bits whose enable is set.
- R6: A write to 0x1010 sets, and a write to 0x1014 clears, each enable bit 11:0 and each steering bit 31:30 written as one. Reads of either offset return steering in bits 31:30 and enables in bits 11:0. irq_steer_o shows the steering field.
- R7: With control bit 3 set (write-one-to-clear mode), a write to 0x1008 clears status bit i when written data bit i or bit 16+i is one. Reads do not change the status.
- R8: With control bit 3 clear (clear-on-read mode), a read of 0x1008 clears every status bit it returned, and writes to 0x1008 have no effect.
- R9: An event arriving in the same cycle as a clear of its status bit leaves that bit set.
- R10: irq_o is high exactly when some status bit and its enable are both set and control bit 0 is clear.
- R11: Read data is registered: it appears on bus_rdata after the edge that samples bus_rd, and holds until the next read. Reads of 0x1004 or of any offset other than 0x1000, 0x1008, 0x1010 and 0x1014 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 13 | Byte offset within the port window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_i | input | 12 | Event pulses, one bit per event source |
| irq_o | output | 1 | Port interrupt request |
| irq_steer_o | output | 2 | Interrupt steering field |

## Verification
The bench reads port-ready one edge before and one edge after the end of the recovery delay. A counter off by one therefore reports ready too early or leaves it low too long. It fires an event in the same cycle as a write-one-to-clear and, separately, in the same cycle as a clearing read. A design that let the clear win would drop that event. It writes ones to the status register in clear-on-read mode, and it reads twice in write-one-to-clear mode, which catches a design that honours the wrong clearing rule. Clears through both the masked and the raw bit positions are exercised. The interrupt is checked with a pending but disabled event, and again while port reset is held, so that a missing mask or a missing reset gate shows up as a spurious interrupt.

// File: rtl/lnk_port_pkg.sv
package lnk_port_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 13;
    localparam int unsigned NUM_EV    = 12;
    localparam int unsigned RAW_LSB   = 16;
    localparam int unsigned STEER_W   = 2;
    localparam int unsigned STEER_LSB = DATA_W - STEER_W;
    localparam int unsigned CTL_W     = DATA_W - 1;

    // control bit positions
    localparam int unsigned CB_PORT_RST = 0;
    localparam int unsigned CB_W1C      = 3;
    localparam int unsigned READY_BIT   = DATA_W - 1;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTL_SET = 13'h1000;
    localparam logic [ADDR_W-1:0] OFS_CTL_CLR = 13'h1004;
    localparam logic [ADDR_W-1:0] OFS_STS     = 13'h1008;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 13'h1010;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 13'h1014;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL_SET,
        SEL_CTL_CLR,
        SEL_STS,
        SEL_EN_SET,
        SEL_EN_CLR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTL_SET: s = SEL_CTL_SET;
            OFS_CTL_CLR: s = SEL_CTL_CLR;
            OFS_STS:     s = SEL_STS;
            OFS_EN_SET:  s = SEL_EN_SET;
            OFS_EN_CLR:  s = SEL_EN_CLR;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lnk_port_ctrl.sv
module lnk_port_ctrl
    import lnk_port_pkg::*;
#(
    parameter int unsigned READY_DELAY = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_o,
    output logic             ready_o
);

    localparam int unsigned CNT_W = $clog2(READY_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(READY_DELAY);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic             ready;
        logic [CNT_W-1:0] cnt;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set_we) s_d.ctl = s_d.ctl | wdata;
        if (clr_we) s_d.ctl = s_d.ctl & ~wdata;

        // ready recovery timer, reloaded while port reset is held
        if (s_d.ctl[CB_PORT_RST]) begin
            s_d.ready = 1'b0;
            s_d.cnt   = CNT_LOAD;
        end else if (!s_q.ready) begin
            if (s_q.cnt == '0) s_d.ready = 1'b1;
            else               s_d.cnt   = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctl   <= '0;
            s_q.ready <= 1'b1;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o   = s_q.ctl;
    assign ready_o = s_q.ready;

endmodule

// File: rtl/lnk_port_irq.sv
module lnk_port_irq
    import lnk_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EV-1:0]  ev_i,
    input  logic               sts_wr,
    input  logic               sts_rd,
    input  logic               en_set_we,
    input  logic               en_clr_we,
    input  logic [NUM_EV-1:0]  wr_lo,
    input  logic [NUM_EV-1:0]  wr_hi,
    input  logic [STEER_W-1:0] wr_steer,
    input  logic               w1c_mode,
    input  logic               port_rst,
    output logic [NUM_EV-1:0]  sts_o,
    output logic [NUM_EV-1:0]  en_o,
    output logic [STEER_W-1:0] steer_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_EV-1:0]  sts;
        logic [NUM_EV-1:0]  en;
        logic [STEER_W-1:0] steer;
    } irq_state_t;

    irq_state_t        s_d, s_q;
    logic [NUM_EV-1:0] clr_mask;

    always_comb begin
        s_d      = s_q;
        clr_mask = '0;

        if (w1c_mode && sts_wr)  clr_mask = wr_lo | wr_hi;
        if (!w1c_mode && sts_rd) clr_mask = s_q.sts;

        // a new event outranks a clear in the same cycle
        s_d.sts = (s_q.sts & ~clr_mask) | ev_i;

        if (en_set_we) begin
            s_d.en    = s_d.en | wr_lo;
            s_d.steer = s_d.steer | wr_steer;
        end
        if (en_clr_we) begin
            s_d.en    = s_d.en & ~wr_lo;
            s_d.steer = s_d.steer & ~wr_steer;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sts_o   = s_q.sts;
    assign en_o    = s_q.en;
    assign steer_o = s_q.steer;
    assign irq_o   = (|(s_q.sts & s_q.en)) & ~port_rst;

endmodule

// File: rtl/lnk_port_regs.sv
module lnk_port_regs
    import lnk_port_pkg::*;
#(
    parameter int unsigned READY_DELAY = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_EV-1:0]  ev_i,
    output logic               irq_o,
    output logic [STEER_W-1:0] irq_steer_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    reg_sel_e          sel;
    logic [CTL_W-1:0]  ctl_word;
    logic              port_ready;
    logic [NUM_EV-1:0] irq_sts;
    logic [NUM_EV-1:0] irq_en;
    logic [DATA_W-1:0] sts_word;
    logic [DATA_W-1:0] en_word;
    rd_state_t         r_d, r_q;

    assign sel = decode_addr(bus_addr);

    lnk_port_ctrl #(
        .READY_DELAY (READY_DELAY)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (bus_wr && sel == SEL_CTL_SET),
        .clr_we  (bus_wr && sel == SEL_CTL_CLR),
        .wdata   (bus_wdata[CTL_W-1:0]),
        .ctl_o   (ctl_word),
        .ready_o (port_ready)
    );

    lnk_port_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_i),
        .sts_wr    (bus_wr && sel == SEL_STS),
        .sts_rd    (bus_rd && sel == SEL_STS),
        .en_set_we (bus_wr && sel == SEL_EN_SET),
        .en_clr_we (bus_wr && sel == SEL_EN_CLR),
        .wr_lo     (bus_wdata[NUM_EV-1:0]),
        .wr_hi     (bus_wdata[RAW_LSB +: NUM_EV]),
        .wr_steer  (bus_wdata[STEER_LSB +: STEER_W]),
        .w1c_mode  (ctl_word[CB_W1C]),
        .port_rst  (ctl_word[CB_PORT_RST]),
        .sts_o     (irq_sts),
        .en_o      (irq_en),
        .steer_o   (irq_steer_o),
        .irq_o     (irq_o)
    );

    always_comb begin
        sts_word                       = '0;
        sts_word[NUM_EV-1:0]           = irq_sts & irq_en;
        sts_word[RAW_LSB +: NUM_EV]    = irq_sts;
        en_word                        = '0;
        en_word[NUM_EV-1:0]            = irq_en;
        en_word[STEER_LSB +: STEER_W]  = irq_steer_o;

        r_d = r_q;
        if (bus_rd) begin
            case (sel)
                SEL_CTL_SET:           r_d.rdata = {port_ready, ctl_word};
                SEL_STS:               r_d.rdata = sts_word;
                SEL_EN_SET, SEL_EN_CLR: r_d.rdata = en_word;
                default:               r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;

endmodule

// File: rtl/lnk_port_regs_chk.sv
module lnk_port_regs_chk
    import lnk_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_EV-1:0] ev_i,
    input logic              irq_o,
    input logic [CTL_W-1:0]  ctl,
    input logic              ready,
    input logic [NUM_EV-1:0] sts,
    input logic [NUM_EV-1:0] en
);

    AST_IRQ_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[CB_PORT_RST] |-> !irq_o); // R10

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((sts & en) != '0)); // R10

    AST_NOT_READY_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[CB_PORT_RST] |-> !ready); // R4

    AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((sts & $past(ev_i)) == $past(ev_i))); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_STS && !ctl[CB_W1C]) |=> (sts == $past(ev_i))); // R8

    AST_W1C_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CB_W1C] && !(bus_wr && bus_addr == OFS_STS)) |=> ((sts & $past(sts)) == $past(sts))); // R7

endmodule

bind lnk_port_regs lnk_port_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .ev_i     (ev_i),
    .irq_o    (irq_o),
    .ctl      (ctl_word),
    .ready    (port_ready),
    .sts      (irq_sts),
    .en       (irq_en)
);

// File: tb/lnk_port_regs_test.sv
`timescale 1ns/1ps
module lnk_port_regs_test;

    localparam int unsigned DLY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] ev_i = '0;
    logic        irq_o;
    logic [1:0]  irq_steer_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lnk_port_regs #(.READY_DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_i(ev_i), .irq_o(irq_o), .irq_steer_o(irq_steer_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic cyc(input logic wr, input logic rd, input logic [12:0] a,
                       input logic [31:0] d, input logic [11:0] ev);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; ev_i = ev;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; ev_i = '0;
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, '0);
    endtask

    task automatic rd_chk(input string req, input logic [12:0] a, input logic [31:0] exp);
        cyc(1'b0, 1'b1, a, '0, '0);
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [11:0] m);
        cyc(1'b0, 1'b0, '0, '0, m);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        check("R1 steer", {30'd0, irq_steer_o}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rd_chk("R1 ctl", 13'h1000, 32'h8000_0000);
        rd_chk("R1 sts", 13'h1008, 32'h0);
        rd_chk("R1 en", 13'h1010, 32'h0);
    endtask

    task automatic t_ctrl;
        wr(13'h1000, 32'h0000_0026);
        rd_chk("R2 set", 13'h1000, 32'h8000_0026);
        wr(13'h1004, 32'h8000_0004);
        rd_chk("R3 clear", 13'h1004 - 13'h4, 32'h8000_0022);
        wr(13'h1004, 32'h7FFF_FFFF);
        rd_chk("R3 clear all", 13'h1000, 32'h8000_0000);
    endtask

    task automatic t_ready;
        wr(13'h1000, 32'h1);
        rd_chk("R4 not ready", 13'h1000, 32'h0000_0001);
        wr(13'h1004, 32'h1);
        idle(DLY - 1);
        rd_chk("R4 still low at delay", 13'h1000, 32'h0);
        rd_chk("R4 ready back", 13'h1000, 32'h8000_0000);
    endtask

    task automatic t_events;
        pulse(12'h091);
        rd_chk("R5 raw only", 13'h1008, 32'h0091_0000);
        wr(13'h1010, 32'h0000_0011);
        pulse(12'h091);
        rd_chk("R5 masked+raw", 13'h1008, 32'h0091_0011);
        rd_chk("R5 cleared", 13'h1008, 32'h0);
        wr(13'h1014, 32'h0000_0011);
    endtask

    task automatic t_enable;
        wr(13'h1010, 32'h8000_0711);
        rd_chk("R6 en set", 13'h1010, 32'h8000_0711);
        check("R6 steer out", {30'd0, irq_steer_o}, 32'd2);
        wr(13'h1014, 32'hC000_0010);
        rd_chk("R6 en clr", 13'h1014, 32'h0000_0701);
        check("R6 steer cleared", {30'd0, irq_steer_o}, 32'd0);
        wr(13'h1014, 32'hFFFF_FFFF);
        rd_chk("R6 en none", 13'h1010, 32'h0);
    endtask

    task automatic t_w1c;
        wr(13'h1000, 32'h8);
        pulse(12'h606);
        rd_chk("R7 pending", 13'h1008, 32'h0606_0000);
        rd_chk("R7 read keeps", 13'h1008, 32'h0606_0000);
        wr(13'h1008, 32'h0000_0002);
        rd_chk("R7 clear low pos", 13'h1008, 32'h0604_0000);
        wr(13'h1008, 32'h0400_0000);
        rd_chk("R7 clear raw pos", 13'h1008, 32'h0204_0000);
        wr(13'h1008, 32'h0FFF_0FFF);
        rd_chk("R7 clear all", 13'h1008, 32'h0);
    endtask

    task automatic t_collide;
        cyc(1'b1, 1'b0, 13'h1008, 32'h2, 12'h002);
        rd_chk("R9 w1c collision", 13'h1008, 32'h0002_0000);
        wr(13'h1008, 32'h2);
        wr(13'h1004, 32'h8);
        pulse(12'h001);
        cyc(1'b0, 1'b1, 13'h1008, '0, 12'h001);
        check("R9 cor read value", bus_rdata, 32'h0001_0000);
        rd_chk("R9 cor collision kept", 13'h1008, 32'h0001_0000);
        rd_chk("R9 cor then clear", 13'h1008, 32'h0);
    endtask

    task automatic t_cor;
        pulse(12'h0C0);
        wr(13'h1008, 32'hFFFF_FFFF);
        rd_chk("R8 write ignored", 13'h1008, 32'h00C0_0000);
        rd_chk("R8 read cleared", 13'h1008, 32'h0);
    endtask

    task automatic t_irq;
        wr(13'h1010, 32'h100);
        check("R10 idle", {31'd0, irq_o}, 32'd0);
        pulse(12'h008);
        check("R10 disabled event", {31'd0, irq_o}, 32'd0);
        pulse(12'h100);
        check("R10 enabled event", {31'd0, irq_o}, 32'd1);
        wr(13'h1000, 32'h1);
        check("R10 gated by port reset", {31'd0, irq_o}, 32'd0);
        wr(13'h1004, 32'h1);
        check("R10 after release", {31'd0, irq_o}, 32'd1);
        rd_chk("R10 status", 13'h1008, 32'h0108_0100);
        check("R10 cleared", {31'd0, irq_o}, 32'd0);
        wr(13'h1014, 32'h100);
        idle(DLY + 2);
    endtask

    task automatic t_unmapped;
        rd_chk("R11 ctl clr reads 0", 13'h1004, 32'h0);
        wr(13'h1010, 32'h0000_0F0F);
        rd_chk("R11 en", 13'h1010, 32'h0000_0F0F);
        idle(2);
        check("R11 hold", bus_rdata, 32'h0000_0F0F);
        rd_chk("R11 offset 0", 13'h0000, 32'h0);
        rd_chk("R11 gap", 13'h100C, 32'h0);
        wr(13'h1014, 32'h0000_0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_ready();
        t_events();
        t_enable();
        t_w1c();
        t_collide();
        t_cor();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule